// File: doc/BRIEF.md
# Interval-Halving Endpoint Controller

This block keeps a closed integer interval as two registered endpoints, a lower bound and an upper bound. Each clock it moves one of them onto the truncated midpoint of the current interval, so the interval shrinks by half. Repeated steps walk the midpoint towards the bottom or the top of the range, the way a binary search does. A combinational halving adder forms the midpoint. It uses grouped generate and propagate terms and a chain of group carries. The final carry becomes the top bit of the halved sum.

One input picks the endpoint that collapses. When it is low, the upper bound takes the midpoint. When it is high, the lower bound takes it. The endpoint that is not picked keeps its value. Whatever logic decides the direction of a real search sits outside this block.

The reset input is synchronous. A flop clocked on the falling edge captures it, and the next rising edge applies it. Once the block is out of reset, the interval is the whole unsigned range of the endpoint width. The fraction dropped at each halving means an upward walk stops one short of the top value.

Top module: `ihc_interval_ctrl`

## Requirements
- R1: On a rising edge where the captured reset is active, the lower bound becomes 0 and the upper bound becomes 2^W-1 (255 for W=8). The midpoint output then reads 2^(W-1)-1 (127).
- R2: A falling-edge flop samples `srst`, and the next rising edge acts on the sampled value. A high level on `srst` that does not span a falling edge has no effect.
- R3: The captured reset overrides `dir_up`. Neither bound takes the midpoint on a reset edge, whatever the value of `dir_up`.
- R4: `mid_o` always equals floor((lo_o + hi_o) / 2), computed without overflow. It is combinational in the two bounds.
- R5: With `dir_up` = 0 and no reset, each rising edge loads the upper bound with the midpoint present before that edge. The lower bound holds.
- R6: With `dir_up` = 1 and no reset, each rising edge loads the lower bound with the midpoint present before that edge. The upper bound holds.
- R7: From reset, the first eight midpoint values of a downward walk are 127, 63, 31, 15, 7, 3, 1, 0. Later downward steps leave the output at 0.
- R8: From reset, the first eight midpoint values of an upward walk are 127, 191, 223, 239, 247, 251, 253, 254. Later upward steps leave the output at 254, never 255.
- R9: After any reset, the lower bound never exceeds the upper bound, for any mix of directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The bounds load on the rising edge and reset is sampled on the falling edge. |
| srst | input | 1 | Synchronous reset request, active high. |
| dir_up | input | 1 | Step direction: 0 moves the upper bound down, 1 moves the lower bound up. |
| mid_o | output | W | Truncated midpoint of the current interval. |
| lo_o | output | W | Lower bound register. |
| hi_o | output | W | Upper bound register. |

## Verification
The bench drives both full walks from reset and checks every midpoint against its own model of the interval. It continues past the eighth step to confirm saturation at 0 and at 254. A design that rounds instead of truncating reaches 255 on the upward walk. A design with a broken group carry gives wrong midpoints in the upper bits, most visibly on the upward walk where the sums are large.

The bench also holds `dir_up` high during reset. A design that lets the direction win over reset would load the lower bound instead of clearing it. A short reset pulse that never spans a falling edge must be ignored, so a design that samples reset on the rising edge would wrongly clear the interval. A mixed sequence of directions exposes a design that loads the wrong bound or disturbs the bound that should hold.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

  // Generate/propagate pair for one bit or one group of bits.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Per-bit terms: generate is AND, propagate is XOR (reused for the sum).
  function automatic gp_t gp_bit(input logic a, input logic b);
    gp_t r;
    r.g = a & b;
    r.p = a ^ b;
    return r;
  endfunction

  // Combine a more significant span (hi) with the span below it (lo).
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Carry out of a span, given the carry into it.
  function automatic logic carry_out(input gp_t x, input logic cin);
    return x.g | (x.p & cin);
  endfunction

endpackage

// File: rtl/ihc_rst_capture.sv
module ihc_rst_capture (
  input  logic clk,
  input  logic srst,
  output logic rst_q
);

  // Sampled on the falling edge, so the next rising edge uses a stable value.
  always_ff @(negedge clk) begin
    rst_q <= srst;
  end

endmodule

// File: rtl/ihc_halving_adder.sv
module ihc_halving_adder #(
  parameter int W     = 8,
  parameter int GROUP = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] half_sum
);
  import ihc_pkg::*;

  localparam int NG = (W + GROUP - 1) / GROUP;

  gp_t        bit_gp [W];
  gp_t        pre_gp [W];   // prefix within a group, up to and including bit j
  logic [NG-1:0] grp_c;     // carry out of each group
  logic [W-1:0]  cin;       // carry into each bit
  logic [W-1:0]  sum;

  for (genvar j = 0; j < W; j++) begin : g_bit
    assign bit_gp[j] = gp_bit(a[j], b[j]);

    if ((j % GROUP) == 0) begin : g_head
      assign pre_gp[j] = bit_gp[j];
      if (j == 0) begin : g_first
        assign cin[j] = 1'b0;
      end else begin : g_next
        assign cin[j] = grp_c[j/GROUP - 1];
      end
    end else begin : g_body
      assign pre_gp[j] = gp_merge(bit_gp[j], pre_gp[j-1]);
      assign cin[j]    = carry_out(bit_gp[j-1], cin[j-1]);
    end

    assign sum[j] = bit_gp[j].p ^ cin[j];
  end

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int HI = ((k + 1) * GROUP > W) ? (W - 1) : ((k + 1) * GROUP - 1);
    if (k == 0) begin : g_c0
      assign grp_c[k] = carry_out(pre_gp[HI], 1'b0);
    end else begin : g_cn
      assign grp_c[k] = carry_out(pre_gp[HI], grp_c[k-1]);
    end
  end

  // Halving: drop bit 0, final carry becomes the MSB.
  assign half_sum = {grp_c[NG-1], sum[W-1:1]};

endmodule

// File: rtl/ihc_endpoint_reg.sv
module ihc_endpoint_reg #(
  parameter int          W         = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (clear) begin
      q <= RESET_VAL;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/ihc_interval_ctrl.sv
module ihc_interval_ctrl #(
  parameter int W     = 8,
  parameter int GROUP = 2
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         dir_up,
  output logic [W-1:0] mid_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);

  localparam logic [W-1:0] LO_INIT = '0;
  localparam logic [W-1:0] HI_INIT = '1;

  logic         rst_q;
  logic         load_left;
  logic         load_right;
  logic [W-1:0] left_q;
  logic [W-1:0] right_q;
  logic [W-1:0] mid_w;

  ihc_rst_capture u_rst (
    .clk   (clk),
    .srst  (srst),
    .rst_q (rst_q)
  );

  // Reset wins; otherwise exactly one endpoint is selected by direction.
  always_comb begin
    load_left  = 1'b0;
    load_right = 1'b0;
    if (!rst_q) begin
      load_left  = dir_up;
      load_right = !dir_up;
    end
  end

  ihc_endpoint_reg #(.W(W), .RESET_VAL(LO_INIT)) u_left (
    .clk   (clk),
    .clear (rst_q),
    .load  (load_left),
    .d     (mid_w),
    .q     (left_q)
  );

  ihc_endpoint_reg #(.W(W), .RESET_VAL(HI_INIT)) u_right (
    .clk   (clk),
    .clear (rst_q),
    .load  (load_right),
    .d     (mid_w),
    .q     (right_q)
  );

  ihc_halving_adder #(.W(W), .GROUP(GROUP)) u_add (
    .a        (left_q),
    .b        (right_q),
    .half_sum (mid_w)
  );

  assign mid_o = mid_w;
  assign lo_o  = left_q;
  assign hi_o  = right_q;

endmodule

// File: rtl/ihc_interval_ctrl_chk.sv
module ihc_interval_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_q,
  input logic         dir_up,
  input logic         load_left,
  input logic         load_right,
  input logic [W-1:0] left_q,
  input logic [W-1:0] right_q,
  input logic [W-1:0] mid_w
);

  logic       primed = 1'b0;
  logic [W:0] wide_sum;

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) primed <= 1'b1;
  end

  assign wide_sum = {1'b0, left_q} + {1'b0, right_q};

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!primed)
    rst_q |=> (left_q == '0) && (right_q == '1));

  a_r3_reset_priority: assert property (@(posedge clk) disable iff (!primed)
    rst_q |-> !load_left && !load_right);

  a_r4_mid_truncated: assert property (@(posedge clk) disable iff (!primed)
    !rst_q |-> mid_w == wide_sum[W:1]);

  a_r5_down_moves_right: assert property (@(posedge clk) disable iff (!primed)
    (!rst_q && !dir_up) |=> (right_q == $past(mid_w)) && $stable(left_q));

  a_r6_up_moves_left: assert property (@(posedge clk) disable iff (!primed)
    (!rst_q && dir_up) |=> (left_q == $past(mid_w)) && $stable(right_q));

  a_r9_ordered: assert property (@(posedge clk) disable iff (!primed)
    !rst_q |-> left_q <= right_q);

endmodule

bind ihc_interval_ctrl ihc_interval_ctrl_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .dir_up     (dir_up),
  .load_left  (load_left),
  .load_right (load_right),
  .left_q     (left_q),
  .right_q    (right_q),
  .mid_w      (mid_w)
);

// File: tb/ihc_interval_ctrl_tb.sv
module ihc_interval_ctrl_tb;
  localparam int W = 8;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         srst = 1'b1;
  logic         dir_up = 1'b0;
  logic [W-1:0] mid_o, lo_o, hi_o;

  int n_chk = 0;
  int n_bad = 0;
  int ref_lo, ref_hi;

  always #4 clk = ~clk;

  ihc_interval_ctrl #(.W(W)) u_dut (
    .clk(clk), .srst(srst), .dir_up(dir_up),
    .mid_o(mid_o), .lo_o(lo_o), .hi_o(hi_o)
  );

  function automatic int ref_mid();
    return (ref_lo + ref_hi) / 2;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "lo", int'(lo_o), ref_lo);
    chk(tag, "hi", int'(hi_o), ref_hi);
    chk(tag, "mid", int'(mid_o), ref_mid());
  endtask

  // Reset with a given direction held; checks the reset state (R1, R3).
  task automatic do_reset(input bit dir);
    dir_up = dir;
    srst = 1'b1;
    @(negedge clk);
    @(posedge clk); #2;
    srst = 1'b0;
    ref_lo = 0; ref_hi = TOP;
    chk("R1", "mid after reset", int'(mid_o), (TOP + 1) / 2 - 1);
    chk_all(dir ? "R3" : "R1");
  endtask

  // One step in a direction, checked against the model (R4, R5, R6).
  task automatic step(input bit up, input string tag);
    int m;
    m = ref_mid();
    dir_up = up;
    @(posedge clk); #2;
    if (up) ref_lo = m; else ref_hi = m;
    chk_all(tag);
    chk("R9", "order", int'(lo_o <= hi_o), 1);
  endtask

  task automatic test_down_walk();
    do_reset(1'b0);
    for (int i = 0; i < 7; i++) step(1'b0, "R5");
    chk("R7", "eighth down midpoint", int'(mid_o), 0);
    for (int i = 0; i < 2; i++) step(1'b0, "R7");
    chk("R7", "down saturated", int'(mid_o), 0);
  endtask

  task automatic test_up_walk();
    do_reset(1'b1);
    for (int i = 0; i < 7; i++) step(1'b1, "R6");
    chk("R8", "eighth up midpoint", int'(mid_o), 254);
    for (int i = 0; i < 2; i++) step(1'b1, "R8");
    chk("R8", "up saturated", int'(mid_o), 254);
  endtask

  task automatic test_mixed();
    do_reset(1'b0);
    step(1'b1, "R6");
    step(1'b0, "R5");
    step(1'b1, "R6");
    step(1'b1, "R6");
    step(1'b0, "R5");
    step(1'b1, "R4");
  endtask

  // A reset pulse that misses every falling edge must not clear (R2).
  task automatic test_short_pulse();
    int m;
    do_reset(1'b0);
    step(1'b0, "R5");
    step(1'b1, "R6");
    m = ref_mid();
    dir_up = 1'b0;
    srst = 1'b1;
    #1 srst = 1'b0;
    @(posedge clk); #2;
    ref_hi = m;
    chk_all("R2");
  endtask

  initial begin
    #2;
    test_down_walk();
    test_up_walk();
    test_mixed();
    test_short_pulse();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule